// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog with a 16-bit up-counter, a prescaler that picks one of eight divide ratios, and a request output that a reset controller uses. It is reached over a small 32-bit register bus with two registers: the count register and the control/status register. Every write must carry a fixed key in its upper bits, or it is dropped. A stray store therefore cannot disable the timer or extend its timeout.

Software loads a start value while the timer is stopped. It then sets the enable bit together with a divide code. The counter steps once per prescaled tick. When it passes 0xFFFF it wraps to zero, raises a sticky overflow flag and drives a fixed-length reset request pulse. The timeout is (65536 - loaded value) ticks. A busy flag stays set while a write is still settling into the counting logic, and any write attempted during that window is dropped.

Top module: `guarded_wdt`

## Requirements
- R1: A write to the control/status register (byte address 4) is accepted only when write data bits 31:8 equal 0xA5A5A5. Any other value leaves enable, divide code and overflow unchanged.
- R2: A write to the count register (byte address 0) is accepted only when write data bits 31:16 equal 0x5A5A. The counter then takes bits 15:0. Any other value leaves the counter unchanged.
- R3: Control/status bit 7 is the enable bit. While it is 0 the counter holds its value.
- R4: Control/status bits 2:0 select the divide ratio. Codes 0 to 7 give 1, 4, 16, 32, 64, 128, 1024 and 4096. The prescaler restarts on every accepted write, so after an enabling write the counter has advanced by floor(k/N) k clocks later.
- R5: Control/status bit 4 is the overflow flag. It is set when the enabled counter steps past 0xFFFF, and the counter wraps to 0x0000. The flag is cleared only by an accepted control/status write with bit 4 at 0. Writing it as 1 does not set it.
- R6: The reset request output goes high in the same cycle as the overflow flag is set and stays high for exactly 4 clock cycles.
- R7: Control/status bit 5 reads 1 from an accepted write until 2 prescaled ticks later. Every write attempted while it is 1 is ignored.
- R8: Read data appears one cycle after the address is presented. Key bits read as zero, control/status bits 6 and 3 read as zero, and unmapped addresses read as zero. The ready output is high for one cycle after each write cycle.
- R9: After synchronous reset all registers are zero: timer stopped, divide-by-1, no overflow, no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data including key bits |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Write acknowledge, one cycle after the strobe |
| rst_req | output | 1 | Reset request pulse on counter overflow |

## Verification
The bench uses the default parameters: a 4-bit address, a 4-cycle request pulse and a 2-tick busy window. With these values the full pulse and the busy window are short enough to sample edge by edge. Every divide code, including 4096, is run long enough to see two and three ticks. A counter loaded at 0xFFF0 with divide-by-1 reaches overflow in 16 cycles, so the wrap, the sticky flag and the exact pulse width are covered without long idle runs.

// File: rtl/gwdt_pkg.sv
// Shared constants, types and the divide table of the guarded watchdog.
// Assumes a 32-bit data bus and a 16-bit counter; the key widths follow.
package gwdt_pkg;

    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int CODE_W   = 3;
    localparam int PRESC_W  = 12;

    localparam logic [DATA_W-CNT_W-1:0] KEY_CNT = 16'h5A5A;
    localparam logic [DATA_W-9:0]       KEY_CSR = 24'hA5A5A5;

    localparam int CNT_OFS  = 0;
    localparam int CSR_OFS  = 4;

    localparam int BIT_EN   = 7;
    localparam int BIT_BUSY = 5;
    localparam int BIT_OVF  = 4;

    typedef struct packed {
        logic              en;
        logic              ovf;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    // Terminal count of the prescaler (divide ratio minus one) for a code.
    function automatic logic [PRESC_W-1:0] presc_last(input logic [CODE_W-1:0] code);
        int sh;
        case (code)
            3'd0:    sh = 0;
            3'd1:    sh = 2;
            3'd2:    sh = 4;
            3'd3:    sh = 5;
            3'd4:    sh = 6;
            3'd5:    sh = 7;
            3'd6:    sh = 10;
            default: sh = 12;
        endcase
        return PRESC_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/gwdt_prescaler.sv
// Prescaler: emits a one-cycle tick every N system clocks, N from the code.
// Assumes code only changes together with restart (an accepted write).
// A restart clears the phase and suppresses the tick of that cycle.
module gwdt_prescaler
    import gwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] last;

    // Terminal count of the selected ratio.
    always_comb last = presc_last(code);

    // Tick when the phase reaches its terminal count, unless restarting.
    always_comb tick = (phase_q >= last) && !restart;

    // Phase counter: cleared on reset, restart or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || (phase_q >= last)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/gwdt_regfile.sv
// Register file: key checks, control/status state, busy window, read mux.
// Assumes one write strobe per cycle; reads are address-driven each cycle.
module gwdt_regfile
    import gwdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int BUSY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              tick,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  cnt_val,
    output ctrl_t             ctrl,
    output logic              busy,
    output logic              csr_acc,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_load_val,
    output logic              restart
);

    localparam int BC_W = $clog2(BUSY_TICKS + 1);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_OFS);
    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_OFS);

    ctrl_t           ctrl_q;
    logic [BC_W-1:0] busy_q;
    logic            csr_key_ok;
    logic            cnt_key_ok;
    logic [DATA_W-1:0] csr_word;
    logic            unused_wbits;

    // Reserved data bits are never stored.
    assign unused_wbits = ^{bus_wdata[6:5], bus_wdata[3]};

    // Key comparison for each register.
    always_comb begin
        csr_key_ok = (bus_wdata[DATA_W-1:8] == KEY_CSR);
        cnt_key_ok = (bus_wdata[DATA_W-1:CNT_W] == KEY_CNT);
    end

    // Accept strobes: correct address, correct key, no write in flight.
    always_comb begin
        csr_acc      = bus_we && (bus_addr == A_CSR) && csr_key_ok && !busy;
        cnt_load     = bus_we && (bus_addr == A_CNT) && cnt_key_ok && !busy;
        cnt_load_val = bus_wdata[CNT_W-1:0];
        restart      = csr_acc || cnt_load;
        busy         = (busy_q != '0);
        ctrl         = ctrl_q;
    end

    // Control/status state; overflow is sticky until a keyed clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (csr_acc) begin
            ctrl_q.en   <= bus_wdata[BIT_EN];
            ctrl_q.code <= bus_wdata[CODE_W-1:0];
            ctrl_q.ovf  <= ctrl_q.ovf && bus_wdata[BIT_OVF];
        end else if (wrap) begin
            ctrl_q.ovf  <= 1'b1;
        end
    end

    // Busy window: loaded on accept, counted down on prescaled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (restart) begin
            busy_q <= BC_W'(BUSY_TICKS);
        end else if (tick && (busy_q != '0)) begin
            busy_q <= busy_q - 1'b1;
        end
    end

    // Status word as seen by a reader.
    always_comb begin
        csr_word           = '0;
        csr_word[BIT_EN]   = ctrl_q.en;
        csr_word[BIT_BUSY] = busy;
        csr_word[BIT_OVF]  = ctrl_q.ovf;
        csr_word[CODE_W-1:0] = ctrl_q.code;
    end

    // Registered read mux and write acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_ready <= 1'b0;
        end else begin
            bus_ready <= bus_we;
            case (bus_addr)
                A_CSR:   bus_rdata <= csr_word;
                A_CNT:   bus_rdata <= {{(DATA_W-CNT_W){1'b0}}, cnt_val};
                default: bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/gwdt_counter.sv
// Timeout counter with wrap detection and a fixed-length reset request.
// Assumes load and tick never coincide (a load restarts the prescaler).
module gwdt_counter
    import gwdt_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             rst_req
);

    localparam int PW_W = $clog2(PULSE_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PW_W-1:0]  pulse_q;

    // Wrap happens on an enabled tick at the all-ones value.
    always_comb begin
        wrap    = en && tick && (cnt_q == {CNT_W{1'b1}});
        cnt     = cnt_q;
        rst_req = (pulse_q != '0);
    end

    // Counter: load from the bus, else step on enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Request pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if (wrap) begin
            pulse_q <= PW_W'(PULSE_W);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

endmodule

// File: rtl/guarded_wdt.sv
// Top of the guarded watchdog: register file, prescaler and counter.
// Assumes a single clock domain and synchronous active-low reset.
module guarded_wdt
    import gwdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PULSE_W    = 4,
    parameter int BUSY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              rst_req
);

    ctrl_t             ctrl_w;
    logic              en_w;
    logic [CODE_W-1:0] code_w;
    logic              ovf_w;
    logic              busy_w;
    logic              csr_acc_w;
    logic              cnt_load_w;
    logic [CNT_W-1:0]  cnt_load_val_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              restart_w;
    logic              tick_w;
    logic              wrap_w;

    // Unpack control fields for the datapath.
    always_comb begin
        en_w   = ctrl_w.en;
        code_w = ctrl_w.code;
        ovf_w  = ctrl_w.ovf;
    end

    gwdt_regfile #(
        .ADDR_W     (ADDR_W),
        .BUSY_TICKS (BUSY_TICKS)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_ready    (bus_ready),
        .tick         (tick_w),
        .wrap         (wrap_w),
        .cnt_val      (cnt_w),
        .ctrl         (ctrl_w),
        .busy         (busy_w),
        .csr_acc      (csr_acc_w),
        .cnt_load     (cnt_load_w),
        .cnt_load_val (cnt_load_val_w),
        .restart      (restart_w)
    );

    gwdt_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_w),
        .code    (code_w),
        .tick    (tick_w)
    );

    gwdt_counter #(
        .PULSE_W (PULSE_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .tick     (tick_w),
        .load     (cnt_load_w),
        .load_val (cnt_load_val_w),
        .cnt      (cnt_w),
        .wrap     (wrap_w),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/gwdt_checker.sv
// Property checker for the guarded watchdog, bound to the top module.
// Assumes the top's internal control nets keep their names.
module gwdt_checker
    import gwdt_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int PULSE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              en,
    input logic [CODE_W-1:0] code,
    input logic              ovf,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_load,
    input logic              csr_acc,
    input logic              rst_req
);

    localparam int RUN_W = $clog2(PULSE_W + 2);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_OFS);
    localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_OFS);

    logic [RUN_W-1:0] run_q;

    // Length of the current high run of the request output.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= rst_req ? run_q + 1'b1 : '0;
    end

    a_r1_bad_key_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CSR && bus_wdata[31:8] != KEY_CSR)
        |=> ($stable(en) && $stable(code)));

    a_r2_bad_key_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CNT && bus_wdata[31:16] != KEY_CNT) |-> !cnt_load);

    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_load) |=> $stable(cnt));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !csr_acc) |=> ovf);

    a_r5_ovf_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> rst_req);

    a_r6_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (run_q < RUN_W'(PULSE_W)));

    a_r6_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> (run_q == RUN_W'(PULSE_W)));

    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cnt_load && !csr_acc));

endmodule

bind guarded_wdt gwdt_checker #(
    .ADDR_W  (ADDR_W),
    .PULSE_W (PULSE_W)
) u_gwdt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .en        (en_w),
    .code      (code_w),
    .ovf       (ovf_w),
    .busy      (busy_w),
    .cnt       (cnt_w),
    .cnt_load  (cnt_load_w),
    .csr_acc   (csr_acc_w),
    .rst_req   (rst_req)
);

// File: tb/guarded_wdt_bench.sv
module guarded_wdt_bench;

    localparam logic [3:0] A_CNT = 4'd0;
    localparam logic [3:0] A_CSR = 4'd4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        rst_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int          m_code;
    logic        m_ovf;
    logic [15:0] m_cnt;

    always #5 clk = ~clk;

    guarded_wdt u_guarded_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .rst_req   (rst_req)
    );

    function automatic int f_div(input int code);
        case (code)
            0: return 1;     1: return 4;     2: return 16;   3: return 32;
            4: return 64;    5: return 128;   6: return 1024; default: return 4096;
        endcase
    endfunction

    function automatic logic [31:0] f_csr(input logic en, input logic busy,
                                          input logic ovf, input int code);
        return {24'h0, en, 1'b0, busy, ovf, 1'b0, 3'(code)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        check("R8 ready after write", {31'h0, bus_ready}, 32'h1);
    endtask

    // Called at a negedge; samples data captured at the next edge.
    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] rd2;
        int          hi_cnt;
        void'($urandom(32'h5eed_0017));
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_code = 0; m_ovf = 1'b0;

        // R9 reset state
        check("R9 rst_req after reset", {31'h0, rst_req}, 32'h0);
        do_read(A_CSR, rd); check("R9 csr after reset", rd, 32'h0);
        do_read(A_CNT, rd); check("R9 count after reset", rd, 32'h0);

        // R4 every divide code, R3 hold after disable
        for (int c = 0; c < 8; c++) begin
            int d;
            do_write(A_CNT, 32'h5A5A_0000);
            wait_edges(2 * f_div(m_code));
            do_write(A_CSR, 32'hA5A5_A580 | 32'(c));
            m_code = c;
            d = f_div(c);
            wait_edges(3 * d - 1);
            do_read(A_CNT, rd); check($sformatf("R4 code %0d two ticks", c), rd, 32'd2);
            do_read(A_CNT, rd); check($sformatf("R4 code %0d three ticks", c), rd, 32'd3);
            do_write(A_CSR, 32'hA5A5_A500 | 32'(c));
            wait_edges(2 * d);
            do_read(A_CNT, rd);
            wait_edges(50);
            do_read(A_CNT, rd2);
            check("R3 stopped count", rd, 32'((3 * d + 1) / d));
            check("R3 stopped count holds", rd2, 32'((3 * d + 1) / d));
        end
        m_cnt = 16'd3;

        // R7 busy flag and writes dropped while busy
        do_write(A_CSR, 32'hA5A5_A502);
        m_code = 2;
        do_read(A_CSR, rd); check("R7 busy set after write", rd, f_csr(1'b0, 1'b1, 1'b0, 2));
        do_write(A_CSR, 32'hA5A5_A585);
        do_write(A_CNT, 32'h5A5A_1234);
        wait_edges(2 * 16);
        do_read(A_CSR, rd); check("R7 csr write while busy dropped", rd, f_csr(1'b0, 1'b0, 1'b0, 2));
        do_read(A_CNT, rd); check("R7 count write while busy dropped", rd, {16'h0, m_cnt});

        // R2 counter key
        do_write(A_CNT, 32'h5A5B_1234);
        wait_edges(2 * 16);
        do_read(A_CNT, rd); check("R2 bad count key ignored", rd, {16'h0, m_cnt});
        do_write(A_CNT, 32'h5A5A_ABCD);
        wait_edges(2 * 16);
        do_read(A_CNT, rd); check("R2 keyed count load", rd, 32'h0000_ABCD);

        // R5 R6 overflow at divide-by-1
        do_write(A_CSR, 32'hA5A5_A500);
        m_code = 0;
        wait_edges(2);
        do_write(A_CNT, 32'h5A5A_FFF0);
        wait_edges(2);
        do_write(A_CSR, 32'hA5A5_A580);
        hi_cnt = 0;
        for (int i = 1; i <= 24; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rst_req) hi_cnt++;
            check($sformatf("R6 request at cycle %0d", i), {31'h0, rst_req},
                  {31'h0, (i >= 16 && i <= 19)});
        end
        check("R6 request width", 32'(hi_cnt), 32'd4);
        do_read(A_CSR, rd); check("R5 overflow flag set", rd, f_csr(1'b1, 1'b0, 1'b1, 0));
        do_write(A_CSR, 32'hA5A5_A510);
        wait_edges(2);
        do_read(A_CSR, rd); check("R5 overflow sticky on write of one", rd, f_csr(1'b0, 1'b0, 1'b1, 0));
        do_write(A_CSR, 32'hA5A5_A400);
        wait_edges(2);
        do_read(A_CSR, rd); check("R1 bad csr key ignored", rd, f_csr(1'b0, 1'b0, 1'b1, 0));
        do_write(A_CSR, 32'hA5A5_A500);
        wait_edges(2);
        do_read(A_CSR, rd); check("R5 overflow cleared by keyed zero", rd, 32'h0);

        // R8 unmapped address
        do_write(4'd8, 32'hA5A5_A583);
        wait_edges(2);
        do_read(4'd8, rd); check("R8 unmapped reads zero", rd, 32'h0);
        do_read(A_CSR, rd); check("R8 unmapped write no effect", rd, 32'h0);

        // Random keyed and unkeyed writes while stopped (R1 R2)
        do_write(A_CNT, 32'h5A5A_0000);
        m_cnt = 16'h0;
        wait_edges(2);
        for (int it = 0; it < 40; it++) begin
            logic [7:0]  b;
            logic [31:0] w;
            bit          good;
            good = ($urandom % 10) < 7;
            if ($urandom % 2 == 0) begin
                b = 8'($urandom);
                b[7] = 1'b0;
                b[2:0] = 3'($urandom_range(0, 5));
                w = good ? {24'hA5A5A5, b}
                         : {24'hA5A5A5 ^ (24'h1 << ($urandom % 24)), b};
                if (good) begin
                    m_code = int'(b[2:0]);
                    m_ovf  = m_ovf & b[4];
                end
                do_write(A_CSR, w);
                wait_edges(2 * f_div(m_code));
                do_read(A_CSR, rd);
                check("R1 random csr write", rd, f_csr(1'b0, 1'b0, m_ovf, m_code));
            end else begin
                b = 8'($urandom);
                w = {good ? 16'h5A5A : (16'h5A5A ^ (16'h1 << ($urandom % 16))),
                     16'($urandom)};
                if (good) m_cnt = w[15:0];
                do_write(A_CNT, w);
                wait_edges(2 * f_div(m_code));
                do_read(A_CNT, rd);
                check("R2 random count write", rd, {16'h0, m_cnt});
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule